// File: doc/BRIEF.md
# L1-Normalized Phase Correlator

This block scores candidate disparities for one scale and one orientation of a phase-based stereo matcher. Each accepted pixel delivers a left and a right complex filter response, each with signed real and imaginary parts. Both responses are scaled to unit magnitude under the L1 norm, which means dividing by |Re|+|Im|. For every preshift tau from 0 to MAX_SHIFT, the block forms the real part of the left sample times the conjugate of the right sample taken tau pixels further along the row. Each of these correlation lanes is then smoothed along x with a 1/4, 1/2, 1/4 window. The result is reduced to an 8-bit vote per lane.

The right stream runs MAX_SHIFT pixels ahead of the left one. A shared normalizer feeds each stream into a tap line, and all lanes read from these two tap lines. The pipeline moves only when `in_valid` is high, so the upstream filter bank may deliver pixels at any rate. A later stage combines the votes across scales and orientations and searches them for a peak. MAX_SHIFT is set per scale: 20 at the finest, 10 at the next and 5 at the coarsest.

Top module: `pc_phase_corr`

## Requirements
- R1: While `rst_n` is low and after its release, before any accepted pixel, `out_valid` is 0 and every vote is 0.
- R2: A component v of a response with m = |Re|+|Im| > 0 normalizes to trunc(v*127/m), rounded toward zero. The result lies in [-127,127], and the two normalized magnitudes sum to at most 127.
- R3: A response with Re = Im = 0 normalizes to (0,0), and it adds nothing to any lane.
- R4: Lane tau at left position x computes P = Lre(x)*Rre(x+tau) + Lim(x)*Rim(x+tau) on the normalized values, with |P| <= 16129.
- R5: The vote for lane tau centred at x is floor((P(x-1) + 2*P(x) + P(x+1)) / 512), as a two's-complement byte. It sits at `votes_o` bits [8*tau+7 : 8*tau].
- R6: Accepted pixels are numbered n from 0 after reset. One cycle after pixel n, `out_valid` is high exactly when n >= MAX_SHIFT+3. The votes then belong to centre x = n-2-MAX_SHIFT.
- R7: A cycle with `in_valid` low changes nothing. In the next cycle `out_valid` is 0 and `votes_o` keeps its value.
- R8: Every vote lies in [-127,126]. Matched full-scale inputs of equal sign give 126, and matched full-scale inputs of opposite sign give -127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One pixel pair is presented this cycle |
| left_re | input | IN_W | Left response, real part, signed |
| left_im | input | IN_W | Left response, imaginary part, signed |
| right_re | input | IN_W | Right response (MAX_SHIFT pixels ahead), real part, signed |
| right_im | input | IN_W | Right response, imaginary part, signed |
| out_valid | output | 1 | Votes updated for a new centre pixel |
| votes_o | output | 8*(MAX_SHIFT+1) | Signed 8-bit vote per preshift, lane tau at bits 8*tau upward |

## Verification
The bench builds the block with MAX_SHIFT = 5, which is the coarsest scale, and keeps IN_W at 16. The short fill of eight pixels brings the first-valid boundary of R6 within reach early, and it leaves many pixels to check all six lanes against a reference model. The full 16-bit input width lets the bench drive the most negative code and very large magnitudes into the normalizer. It also drives long runs of zeros, and it inserts stall cycles at random points while the window is half filled.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int PC_NORM_W  = 8;
  localparam int PC_UNIT    = (1 << (PC_NORM_W - 1)) - 1;
  localparam int PC_PROD_W  = 2 * PC_NORM_W + 1;
  localparam int PC_SUM_W   = PC_PROD_W + 2;
  localparam int PC_VOTE_SH = 2 + PC_NORM_W - 1;

  typedef struct packed {
    logic signed [PC_NORM_W-1:0] re;
    logic signed [PC_NORM_W-1:0] im;
  } pc_cplx_t;

  // real part of a * conj(b)
  function automatic logic signed [PC_PROD_W-1:0] pc_dot(input pc_cplx_t a, input pc_cplx_t b);
    logic signed [PC_PROD_W-1:0] p0;
    logic signed [PC_PROD_W-1:0] p1;
    p0 = a.re * b.re;
    p1 = a.im * b.im;
    return p0 + p1;
  endfunction

  // 1/4,1/2,1/4 window then reduction to a vote byte
  function automatic logic signed [PC_NORM_W-1:0] pc_vote(input logic signed [PC_PROD_W-1:0] pa,
                                                         input logic signed [PC_PROD_W-1:0] pb,
                                                         input logic signed [PC_PROD_W-1:0] pc);
    logic signed [PC_SUM_W-1:0] s;
    logic signed [PC_SUM_W-1:0] q;
    s = PC_SUM_W'(pa) + (PC_SUM_W'(pb) <<< 1) + PC_SUM_W'(pc);
    q = s >>> PC_VOTE_SH;
    return PC_NORM_W'(q);
  endfunction
endpackage

// File: rtl/pc_l1_norm.sv
module pc_l1_norm import pc_pkg::*; #(
  parameter int IN_W = 16
) (
  input  logic signed [IN_W-1:0] re_i,
  input  logic signed [IN_W-1:0] im_i,
  output pc_cplx_t               q_o,
  output logic                   zero_o
);
  localparam int AW    = IN_W + 1;
  localparam int NUM_W = AW + PC_NORM_W;

  function automatic logic [AW-1:0] mag1(input logic signed [IN_W-1:0] v);
    logic signed [AW-1:0] x;
    x = {v[IN_W-1], v};
    return x[AW-1] ? AW'(-x) : AW'(x);
  endfunction

  function automatic logic signed [PC_NORM_W-1:0] scale1(input logic signed [IN_W-1:0] v,
                                                       input logic [AW-1:0] m);
    logic [NUM_W-1:0] num;
    logic [NUM_W-1:0] qt;
    logic [PC_NORM_W-1:0] qs;
    if (m == '0) return '0;
    num = NUM_W'(mag1(v)) * NUM_W'(PC_UNIT);
    qt  = num / NUM_W'(m);
    qs  = PC_NORM_W'(qt);
    return v[IN_W-1] ? -qs : qs;
  endfunction

  logic [AW-1:0] mag;

  always_comb begin
    mag     = mag1(re_i) + mag1(im_i);
    zero_o  = (mag == '0);
    q_o.re  = scale1(re_i, mag);
    q_o.im  = scale1(im_i, mag);
  end
endmodule

// File: rtl/pc_tap_line.sv
module pc_tap_line import pc_pkg::*; #(
  parameter int DEPTH = 21
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_i,
  input  pc_cplx_t              din_i,
  output pc_cplx_t [DEPTH-1:0]  taps_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taps_o <= '0;
    end else if (en_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i == 0) taps_o[i] <= din_i;
        else        taps_o[i] <= taps_o[i-1];
      end
    end
  end
endmodule

// File: rtl/pc_lane.sv
module pc_lane import pc_pkg::*; (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en_i,
  input  pc_cplx_t                    l_i,
  input  pc_cplx_t                    r_i,
  output logic signed [PC_PROD_W-1:0] prod_o,
  output logic signed [PC_NORM_W-1:0] vote_o
);
  logic signed [PC_PROD_W-1:0] hist1;
  logic signed [PC_PROD_W-1:0] hist2;

  assign prod_o = pc_dot(l_i, r_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist1  <= '0;
      hist2  <= '0;
      vote_o <= '0;
    end else if (en_i) begin
      hist1  <= prod_o;
      hist2  <= hist1;
      vote_o <= pc_vote(prod_o, hist1, hist2);
    end
  end
endmodule

// File: rtl/pc_phase_corr.sv
module pc_phase_corr import pc_pkg::*; #(
  parameter int MAX_SHIFT = 20,
  parameter int IN_W      = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  input  logic signed [IN_W-1:0]               left_re,
  input  logic signed [IN_W-1:0]               left_im,
  input  logic signed [IN_W-1:0]               right_re,
  input  logic signed [IN_W-1:0]               right_im,
  output logic                                 out_valid,
  output logic [(MAX_SHIFT+1)*PC_NORM_W-1:0]   votes_o
);
  localparam int LANES = MAX_SHIFT + 1;
  localparam int FILL  = MAX_SHIFT + 3;
  localparam int CNT_W = $clog2(FILL + 1);

  pc_cplx_t                       nl;
  pc_cplx_t                       nr;
  logic                           zero_l;
  logic                           zero_r;
  pc_cplx_t [LANES-1:0]           ltaps;
  pc_cplx_t [LANES-1:0]           rtaps;
  logic [LANES*PC_PROD_W-1:0]     lane_prod;
  logic [CNT_W-1:0]               fill;

  pc_l1_norm #(.IN_W(IN_W)) u_norm_l (.re_i(left_re),  .im_i(left_im),  .q_o(nl), .zero_o(zero_l));
  pc_l1_norm #(.IN_W(IN_W)) u_norm_r (.re_i(right_re), .im_i(right_im), .q_o(nr), .zero_o(zero_r));

  pc_tap_line #(.DEPTH(LANES)) u_line_l (.clk(clk), .rst_n(rst_n), .en_i(in_valid), .din_i(nl), .taps_o(ltaps));
  pc_tap_line #(.DEPTH(LANES)) u_line_r (.clk(clk), .rst_n(rst_n), .en_i(in_valid), .din_i(nr), .taps_o(rtaps));

  for (genvar t = 0; t < LANES; t++) begin : g_lane
    pc_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (in_valid),
      .l_i    (ltaps[MAX_SHIFT]),
      .r_i    (rtaps[MAX_SHIFT-t]),
      .prod_o (lane_prod[t*PC_PROD_W +: PC_PROD_W]),
      .vote_o (votes_o[t*PC_NORM_W +: PC_NORM_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid && (fill == CNT_W'(FILL));
      if (in_valid && fill != CNT_W'(FILL)) fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/pc_phase_corr_chk.sv
module pc_phase_corr_chk import pc_pkg::*; #(
  parameter int MAX_SHIFT = 20
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 in_valid,
  input logic                                 out_valid,
  input logic [(MAX_SHIFT+1)*PC_NORM_W-1:0]   votes_o,
  input logic                                 zero_l,
  input logic                                 zero_r,
  input pc_cplx_t                             ltap0,
  input pc_cplx_t                             rtap0,
  input logic [(MAX_SHIFT+1)*PC_PROD_W-1:0]   lane_prod
);
  localparam int LANES = MAX_SHIFT + 1;
  localparam int OPEN  = MAX_SHIFT + 4;
  localparam int CW    = $clog2(OPEN + 1);
  localparam int PMAX  = PC_UNIT * PC_UNIT;

  logic [CW-1:0] seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (in_valid && seen != CW'(OPEN)) seen <= seen + 1'b1;
  end

  function automatic int ab(input logic signed [PC_NORM_W-1:0] v);
    return (v < 0) ? -int'(v) : int'(v);
  endfunction

  AST_NORM_SUM_L: assert property (@(posedge clk) disable iff (!rst_n)
    ab(ltap0.re) + ab(ltap0.im) <= PC_UNIT); // R2
  AST_NORM_SUM_R: assert property (@(posedge clk) disable iff (!rst_n)
    ab(rtap0.re) + ab(rtap0.im) <= PC_UNIT); // R2
  AST_ZERO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && zero_l |=> ltap0 == '0); // R3
  AST_ZERO_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && zero_r |=> rtap0 == '0); // R3
  AST_FILL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> seen >= CW'(OPEN)); // R6
  AST_FILL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && seen >= CW'(OPEN - 1) |=> out_valid); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(votes_o)); // R7

  for (genvar t = 0; t < LANES; t++) begin : g_lane_chk
    logic signed [PC_PROD_W-1:0] p;
    logic signed [PC_NORM_W-1:0] v;
    assign p = lane_prod[t*PC_PROD_W +: PC_PROD_W];
    assign v = votes_o[t*PC_NORM_W +: PC_NORM_W];
    AST_LANE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      p <= PC_PROD_W'(PMAX) && p >= -PC_PROD_W'(PMAX)); // R4
    AST_VOTE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      v >= -PC_NORM_W'(PC_UNIT) && v <= PC_NORM_W'(PC_UNIT - 1)); // R8
  end
endmodule

bind pc_phase_corr pc_phase_corr_chk #(.MAX_SHIFT(MAX_SHIFT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .votes_o   (votes_o),
  .zero_l    (zero_l),
  .zero_r    (zero_r),
  .ltap0     (ltaps[0]),
  .rtap0     (rtaps[0]),
  .lane_prod (lane_prod)
);

// File: tb/sim_pc_phase_corr.sv
module sim_pc_phase_corr;
  localparam int D     = 5;
  localparam int IN_W  = 16;
  localparam int LANES = D + 1;
  localparam int NB    = 2048;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                    rst_n;
  logic                    in_valid;
  logic signed [IN_W-1:0]  left_re, left_im, right_re, right_im;
  logic                    out_valid;
  logic [LANES*8-1:0]      votes_o;

  pc_phase_corr #(.MAX_SHIFT(D), .IN_W(IN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .left_re(left_re), .left_im(left_im), .right_re(right_re), .right_im(right_im),
    .out_valid(out_valid), .votes_o(votes_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int nbeat = 0;
  int lre[NB], lim[NB], rre[NB], rim[NB];
  logic [LANES*8-1:0] prev_votes;
  string tag;

  function automatic int nrm(int a, int b);
    int m;
    m = (a < 0 ? -a : a) + (b < 0 ? -b : b);
    if (m == 0) return 0;
    return (a * 127) / m;
  endfunction

  function automatic int pv(int x, int t);
    return lre[x] * rre[x+t] + lim[x] * rim[x+t];
  endfunction

  function automatic int ev(int xc, int t);
    int s;
    s = pv(xc-1, t) + 2 * pv(xc, t) + pv(xc+1, t);
    if (s >= 0) return s / 512;
    return -((-s + 511) / 512);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] act=%0d exp=%0d at beat %0d", req, tag, act, exp, nbeat);
    end
  endtask

  task automatic beat(bit v, int a, int b, int c, int d);
    int n;
    in_valid = v;
    left_re = a[15:0]; left_im = b[15:0]; right_re = c[15:0]; right_im = d[15:0];
    @(posedge clk); #1;
    if (v && nbeat < NB) begin
      lre[nbeat] = nrm(int'($signed(a[15:0])), int'($signed(b[15:0])));
      lim[nbeat] = nrm(int'($signed(b[15:0])), int'($signed(a[15:0])));
      rre[nbeat] = nrm(int'($signed(c[15:0])), int'($signed(d[15:0])));
      rim[nbeat] = nrm(int'($signed(d[15:0])), int'($signed(c[15:0])));
      n = nbeat;
      nbeat++;
      chk(out_valid == (n >= D + 3), "R6 out_valid", int'(out_valid), int'(n >= D + 3));
      if (n >= D + 3) begin
        for (int t = 0; t < LANES; t++) begin
          int act, exp;
          act = int'($signed(votes_o[t*8 +: 8]));
          exp = ev(n - 2 - D, t);
          chk(act == exp, "R4 R5 vote", act, exp);
          chk(act >= -127 && act <= 126, "R8 range", act, exp);
        end
      end
    end else begin
      chk(out_valid == 1'b0, "R7 stall valid", int'(out_valid), 0);
      chk(votes_o == prev_votes, "R7 stall hold", int'(votes_o[7:0]), int'(prev_votes[7:0]));
    end
    prev_votes = votes_o;
  endtask

  function automatic int rnd16();
    int k;
    k = int'($urandom_range(0, 3));
    if (k == 0) return int'($urandom_range(0, 16)) - 8;
    if (k == 1) return 0;
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog act=0 exp=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 1'b0; in_valid = 1'b0;
    left_re = '0; left_im = '0; right_re = '0; right_im = '0;
    repeat (3) @(posedge clk);
    #1;
    tag = "reset";
    chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    chk(votes_o == '0, "R1 votes", int'(votes_o[7:0]), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(out_valid == 1'b0 && votes_o == '0, "R1 idle", int'(out_valid), 0);
    prev_votes = votes_o;

    tag = "R2 full scale same sign";
    for (int i = 0; i < 14; i++) beat(1'b1, 1000, 0, 5, 0);
    chk(int'($signed(votes_o[7:0])) == 126, "R8 max vote", int'($signed(votes_o[7:0])), 126);

    tag = "R2 most negative code";
    for (int i = 0; i < 10; i++) beat(1'b1, -32768, 0, 3, 0);
    chk(int'($signed(votes_o[LANES*8-1 -: 8])) == -127, "R8 min vote",
        int'($signed(votes_o[LANES*8-1 -: 8])), -127);

    tag = "R3 zero left";
    for (int i = 0; i < 12; i++) beat(1'b1, 0, 0, rnd16(), rnd16());
    for (int t = 0; t < LANES; t++)
      chk(votes_o[t*8 +: 8] == 8'd0, "R3 zero votes", int'($signed(votes_o[t*8 +: 8])), 0);

    tag = "R2 mixed quadrants";
    for (int i = 0; i < 16; i++) beat(1'b1, (i % 2) ? 300 : -700, (i % 3) ? -123 : 40, -90, 7 * i);

    tag = "R7 stall mid window";
    beat(1'b1, 12000, -5000, 300, 300);
    beat(1'b0, 1, 2, 3, 4);
    beat(1'b0, -9, 9, -9, 9);
    beat(1'b1, -4, 4, 100, -2);

    tag = "R4 R5 random";
    for (int i = 0; i < 600; i++) begin
      bit v;
      v = ($urandom_range(0, 9) < 8);
      beat(v, rnd16(), rnd16(), rnd16(), rnd16());
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule